// File: doc/BRIEF.md
# Power Mode and Wake Sequencer

This block decides which of three power states a small controller core is in and how it moves between them. In the running state the core and its peripherals are clocked. A halt request parks the core in a waiting state where only the core clock is stopped. Peripheral clocks keep running so timers and interrupts stay alive, and any enabled interrupt or a reset request resumes execution. A write of the sleep bit drops everything into a deep state where peripheral clocks stop and peripheral logic is held in reset. That write only takes effect when a separate permission bit was set earlier.

The deep state can only be left through a one-cycle reset pass state. Two things trigger it: the input-combination reset from the external pins, or a built-in wake timer. The wake timer counts a low-rate tick and offers eight timeouts. The permission bit is cleared only by power-on reset. Software can therefore read it after start-up to tell a cold power-up (0) from a wake from the deep state (1).

States: RUN (code 0), WAIT (code 1), DEEP (code 2), WAKE_RST (code 3). Transitions:
- RUN to WAIT on halt.
- RUN to DEEP on a permitted sleep write.
- RUN or WAIT to WAKE_RST on a non-suppressed pin reset.
- WAIT to RUN on interrupt.
- DEEP to WAKE_RST on a pin reset or a timer wake.
- WAKE_RST to RUN always.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While and after power-on reset (rst_n low), the outputs are mode=0 (RUN), cpu_clk_en=1, periph_clk_en=1, periph_rst=0, sleep_en=0, sleep_flag=0 and wake_rst=0.
- R2: In RUN, a halt_req moves the block to WAIT (mode=1) at the next edge, with cpu_clk_en=0 and periph_clk_en=1. It stays in WAIT without further input.
- R3: In WAIT, irq_pending returns the block to RUN at the next edge. In RUN, irq_pending has no effect on mode.
- R4: In RUN with sleep_en=1, sleep_wr moves the block to DEEP (mode=2) with cpu_clk_en=0, periph_clk_en=0, periph_rst=1 and sleep_flag=1. A sleep_wr takes priority over a halt_req in the same cycle.
- R5: A sleep_wr while sleep_en=0 is ignored and the block stays in RUN. A halt_req in the same cycle still leads to WAIT.
- R6: sleep_en takes sleep_en_wdata when sleep_en_wr is high in RUN. It keeps its value through DEEP and WAKE_RST, and only rst_n clears it.
- R7: In DEEP, irq_pending is ignored. ext_rst_req ends DEEP even when ext_rst_inhibit=1.
- R8: In RUN or WAIT, ext_rst_req with ext_rst_inhibit=0 moves the block to WAKE_RST. With ext_rst_inhibit=1 it is ignored.
- R9: WAKE_RST (mode=3) lasts exactly one cycle with periph_rst=1, cpu_clk_en=0, periph_clk_en=1 and sleep_flag=0, then RUN follows.
- R10: In DEEP the wake timer counts slow_tick pulses. On the edge that takes the (4 << scr_sel)-th tick, wake_rst pulses for one cycle, and at the following edge the mode becomes WAKE_RST.
- R11: With scr_inhibit=1 the wake timer never raises wake_rst. The count restarts from zero on every entry to DEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| halt_req | input | 1 | Halt instruction strobe |
| sleep_wr | input | 1 | Write of 1 to the sleep bit |
| sleep_en_wr | input | 1 | Write strobe for the sleep permission bit |
| sleep_en_wdata | input | 1 | Value written to the permission bit |
| irq_pending | input | 1 | Any enabled interrupt request |
| ext_rst_req | input | 1 | Input-combination reset request from the pins |
| ext_rst_inhibit | input | 1 | Option suppressing the pin reset outside DEEP |
| slow_tick | input | 1 | Low-rate enable for the wake timer |
| scr_sel | input | 3 | Wake timeout select, 4 << scr_sel ticks |
| scr_inhibit | input | 1 | Disables the wake timer |
| mode | output | 2 | Current state code |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| periph_rst | output | 1 | Peripheral reset |
| sleep_en | output | 1 | Sleep permission bit (1 = woke from DEEP) |
| sleep_flag | output | 1 | Set while in DEEP |
| wake_rst | output | 1 | One-cycle wake pulse from the timer |

## Verification
Two conflicts matter most. The first is the wake timer reaching its terminal count on the same edge that a pin reset arrives in DEEP. The bench lines up the final tick with ext_rst_req and requires a single WAKE_RST cycle: wake_rst high in that cycle, then RUN. The second is a halt and a sleep write issued together. With permission set this must go to DEEP, and with permission clear it must go to WAIT, which shows that the guard falls back to the halt path.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_RUN      = 2'd0,
        PM_WAIT     = 2'd1,
        PM_DEEP     = 2'd2,
        PM_WAKE_RST = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic cpu_clk_en;
        logic periph_clk_en;
        logic periph_rst;
    } pm_gates_t;

endpackage

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_req,
    input  logic      sleep_wr,
    input  logic      sleep_en,
    input  logic      irq_pending,
    input  logic      ext_rst_req,
    input  logic      ext_rst_inhibit,
    input  logic      scr_wake,
    output pm_state_e state_q,
    output pm_state_e state_d,
    output pm_gates_t gates
);

    logic pin_rst_awake;

    assign pin_rst_awake = ext_rst_req & ~ext_rst_inhibit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (pin_rst_awake)          state_d = PM_WAKE_RST;
                else if (sleep_wr && sleep_en) state_d = PM_DEEP;
                else if (halt_req)          state_d = PM_WAIT;
            end
            PM_WAIT: begin
                if (pin_rst_awake)          state_d = PM_WAKE_RST;
                else if (irq_pending)       state_d = PM_RUN;
            end
            PM_DEEP: begin
                if (ext_rst_req || scr_wake) state_d = PM_WAKE_RST;
            end
            PM_WAKE_RST: state_d = PM_RUN;
            default:     state_d = PM_RUN;
        endcase
    end

    always_comb begin
        gates = '{cpu_clk_en: 1'b1, periph_clk_en: 1'b1, periph_rst: 1'b0};
        unique case (state_q)
            PM_RUN:      gates = '{cpu_clk_en: 1'b1, periph_clk_en: 1'b1, periph_rst: 1'b0};
            PM_WAIT:     gates = '{cpu_clk_en: 1'b0, periph_clk_en: 1'b1, periph_rst: 1'b0};
            PM_DEEP:     gates = '{cpu_clk_en: 1'b0, periph_clk_en: 1'b0, periph_rst: 1'b1};
            PM_WAKE_RST: gates = '{cpu_clk_en: 1'b0, periph_clk_en: 1'b1, periph_rst: 1'b1};
            default:     gates = '{cpu_clk_en: 1'b1, periph_clk_en: 1'b1, periph_rst: 1'b0};
        endcase
    end

endmodule

// File: rtl/pmc_ctl_regs.sv
module pmc_ctl_regs
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pm_state_e state_q,
    input  pm_state_e state_d,
    input  logic      sleep_en_wr,
    input  logic      sleep_en_wdata,
    output logic      sleep_en,
    output logic      sleep_flag
);

    logic core_running;

    assign core_running = (state_q == PM_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_en   <= 1'b0;
            sleep_flag <= 1'b0;
        end else begin
            if (core_running && sleep_en_wr) sleep_en <= sleep_en_wdata;
            sleep_flag <= (state_d == PM_DEEP);
        end
    end

endmodule

// File: rtl/pmc_sleep_ctr.sv
module pmc_sleep_ctr #(
    parameter int SEL_W      = 3,
    parameter int BASE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_sleep,
    input  logic             slow_tick,
    input  logic [SEL_W-1:0] scr_sel,
    input  logic             scr_inhibit,
    output logic             wake
);

    localparam int NSEL    = 1 << SEL_W;
    localparam int MAX_LIM = BASE_TICKS << (NSEL - 1);
    localparam int CW      = $clog2(MAX_LIM);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_val;
    logic [CW-1:0] lim_tbl [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim_tbl[g] = CW'((BASE_TICKS << g) - 1);
    end

    assign last_val = lim_tbl[scr_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            wake <= 1'b0;
        end else if (!in_sleep || scr_inhibit) begin
            cnt  <= '0;
            wake <= 1'b0;
        end else if (slow_tick) begin
            if (cnt >= last_val) begin
                cnt  <= '0;
                wake <= 1'b1;
            end else begin
                cnt  <= cnt + 1'b1;
                wake <= 1'b0;
            end
        end else begin
            wake <= 1'b0;
        end
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int SEL_W      = 3,
    parameter int BASE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_req,
    input  logic             sleep_wr,
    input  logic             sleep_en_wr,
    input  logic             sleep_en_wdata,
    input  logic             irq_pending,
    input  logic             ext_rst_req,
    input  logic             ext_rst_inhibit,
    input  logic             slow_tick,
    input  logic [SEL_W-1:0] scr_sel,
    input  logic             scr_inhibit,
    output logic [1:0]       mode,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             periph_rst,
    output logic             sleep_en,
    output logic             sleep_flag,
    output logic             wake_rst
);

    pm_state_e state_q;
    pm_state_e state_d;
    pm_gates_t gates;

    pmc_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .halt_req        (halt_req),
        .sleep_wr        (sleep_wr),
        .sleep_en        (sleep_en),
        .irq_pending     (irq_pending),
        .ext_rst_req     (ext_rst_req),
        .ext_rst_inhibit (ext_rst_inhibit),
        .scr_wake        (wake_rst),
        .state_q         (state_q),
        .state_d         (state_d),
        .gates           (gates)
    );

    pmc_ctl_regs u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .state_q        (state_q),
        .state_d        (state_d),
        .sleep_en_wr    (sleep_en_wr),
        .sleep_en_wdata (sleep_en_wdata),
        .sleep_en       (sleep_en),
        .sleep_flag     (sleep_flag)
    );

    pmc_sleep_ctr #(.SEL_W(SEL_W), .BASE_TICKS(BASE_TICKS)) u_scr (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_sleep    (state_q == PM_DEEP),
        .slow_tick   (slow_tick),
        .scr_sel     (scr_sel),
        .scr_inhibit (scr_inhibit),
        .wake        (wake_rst)
    );

    assign mode          = state_q;
    assign cpu_clk_en    = gates.cpu_clk_en;
    assign periph_clk_en = gates.periph_clk_en;
    assign periph_rst    = gates.periph_rst;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt_req,
    input logic             sleep_wr,
    input logic             ext_rst_req,
    input logic             ext_rst_inhibit,
    input logic             scr_inhibit,
    input logic [1:0]       mode,
    input logic             cpu_clk_en,
    input logic             periph_rst,
    input logic             sleep_en,
    input logic             wake_rst
);

    a_r2_halt_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && halt_req && !sleep_wr && !ext_rst_req) |=> (mode == 2'd1 && !cpu_clk_en));

    a_r5_no_sleep_without_en: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && sleep_wr && !sleep_en) |=> (mode != 2'd2));

    a_r6_en_held_in_deep: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> sleep_en);

    a_r7_deep_needs_reset_src: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !ext_rst_req && !wake_rst) |=> (mode == 2'd2));

    a_r8_inhibited_pin_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && ext_rst_req && ext_rst_inhibit && !sleep_wr && !halt_req) |=> (mode == 2'd0));

    a_r9_single_reset_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> (mode == 2'd0 && !periph_rst));

    a_r10_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rst |=> !wake_rst);

    a_r11_inhibit_blocks_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_inhibit && $past(scr_inhibit)) |-> !wake_rst);

endmodule

bind pwr_mode_ctrl pmc_checker #(.SEL_W(SEL_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .halt_req        (halt_req),
    .sleep_wr        (sleep_wr),
    .ext_rst_req     (ext_rst_req),
    .ext_rst_inhibit (ext_rst_inhibit),
    .scr_inhibit     (scr_inhibit),
    .mode            (mode),
    .cpu_clk_en      (cpu_clk_en),
    .periph_rst      (periph_rst),
    .sleep_en        (sleep_en),
    .wake_rst        (wake_rst)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 0, sleep_wr = 0, sleep_en_wr = 0, sleep_en_wdata = 0;
    logic       irq_pending = 0, ext_rst_req = 0, ext_rst_inhibit = 0;
    logic       slow_tick = 0, scr_inhibit = 0;
    logic [2:0] scr_sel = 3'd0;
    logic [1:0] mode;
    logic       cpu_clk_en, periph_clk_en, periph_rst, sleep_en, sleep_flag, wake_rst;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pwr_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_wr(sleep_wr),
        .sleep_en_wr(sleep_en_wr), .sleep_en_wdata(sleep_en_wdata),
        .irq_pending(irq_pending), .ext_rst_req(ext_rst_req),
        .ext_rst_inhibit(ext_rst_inhibit), .slow_tick(slow_tick),
        .scr_sel(scr_sel), .scr_inhibit(scr_inhibit), .mode(mode),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .periph_rst(periph_rst), .sleep_en(sleep_en),
        .sleep_flag(sleep_flag), .wake_rst(wake_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) cyc();
        check("R1 mode in reset", mode, 0);
        rst_n = 1;
        cyc();
        check("R1 mode", mode, 0);
        check("R1 cpu_clk_en", cpu_clk_en, 1);
        check("R1 periph_clk_en", periph_clk_en, 1);
        check("R1 periph_rst", periph_rst, 0);
        check("R1 sleep_en", sleep_en, 0);
        check("R1 sleep_flag", sleep_flag, 0);
        check("R1 wake_rst", wake_rst, 0);
    endtask

    task automatic t_halt_irq();
        halt_req = 1; cyc(); halt_req = 0;
        check("R2 mode wait", mode, 1);
        check("R2 cpu_clk_en", cpu_clk_en, 0);
        check("R2 periph_clk_en", periph_clk_en, 1);
        repeat (3) cyc();
        check("R2 stays wait", mode, 1);
        irq_pending = 1; cyc(); irq_pending = 0;
        check("R3 irq resumes", mode, 0);
        check("R3 cpu_clk_en", cpu_clk_en, 1);
        irq_pending = 1; cyc(); irq_pending = 0;
        check("R3 irq in run no effect", mode, 0);
    endtask

    task automatic t_sleep_blocked();
        sleep_wr = 1; cyc(); sleep_wr = 0;
        check("R5 write ignored", mode, 0);
        check("R5 flag clear", sleep_flag, 0);
        sleep_wr = 1; halt_req = 1; cyc(); sleep_wr = 0; halt_req = 0;
        check("R5 halt still taken", mode, 1);
        irq_pending = 1; cyc(); irq_pending = 0;
        check("R3 back to run", mode, 0);
    endtask

    task automatic t_deep_pin_wake();
        sleep_en_wr = 1; sleep_en_wdata = 1; cyc(); sleep_en_wr = 0; sleep_en_wdata = 0;
        check("R6 sleep_en set", sleep_en, 1);
        scr_inhibit = 1;
        sleep_wr = 1; halt_req = 1; cyc(); sleep_wr = 0; halt_req = 0;
        check("R4 deep mode", mode, 2);
        check("R4 flag", sleep_flag, 1);
        check("R4 cpu_clk_en", cpu_clk_en, 0);
        check("R4 periph_clk_en", periph_clk_en, 0);
        check("R4 periph_rst", periph_rst, 1);
        irq_pending = 1; cyc(); irq_pending = 0;
        check("R7 irq ignored in deep", mode, 2);
        ext_rst_inhibit = 1; ext_rst_req = 1; cyc(); ext_rst_req = 0;
        check("R7 pin reset despite option", mode, 3);
        check("R9 periph_rst", periph_rst, 1);
        check("R9 cpu_clk_en", cpu_clk_en, 0);
        check("R9 periph_clk_en", periph_clk_en, 1);
        check("R9 flag cleared", sleep_flag, 0);
        cyc();
        check("R9 back to run", mode, 0);
        check("R6 sleep_en kept", sleep_en, 1);
        ext_rst_inhibit = 0; scr_inhibit = 0;
    endtask

    task automatic t_pin_option();
        ext_rst_inhibit = 1; ext_rst_req = 1; cyc(); ext_rst_req = 0;
        check("R8 inhibited in run", mode, 0);
        ext_rst_inhibit = 0; ext_rst_req = 1; cyc(); ext_rst_req = 0;
        check("R8 reset from run", mode, 3);
        cyc();
        check("R9 run after reset", mode, 0);
        halt_req = 1; cyc(); halt_req = 0;
        ext_rst_inhibit = 1; ext_rst_req = 1; cyc(); ext_rst_req = 0;
        check("R8 inhibited in wait", mode, 1);
        ext_rst_inhibit = 0; ext_rst_req = 1; cyc(); ext_rst_req = 0;
        check("R8 reset from wait", mode, 3);
        cyc();
    endtask

    task automatic t_scr(input logic [2:0] sel);
        int n = 4 << sel;
        scr_sel = sel;
        sleep_wr = 1; cyc(); sleep_wr = 0;
        check("R10 deep entry", mode, 2);
        for (int i = 1; i <= n; i++) begin
            slow_tick = 1; cyc(); slow_tick = 0;
            if (i < n) begin
                if (wake_rst !== 1'b0 || mode !== 2'd2)
                    check("R10 early wake", {wake_rst, mode}, 2);
                cyc();
            end
        end
        check("R10 wake pulse", wake_rst, 1);
        check("R10 still deep", mode, 2);
        cyc();
        check("R10 reset pass", mode, 3);
        check("R10 pulse ended", wake_rst, 0);
        cyc();
        check("R10 run", mode, 0);
    endtask

    task automatic t_scr_restart();
        scr_sel = 0;
        sleep_wr = 1; cyc(); sleep_wr = 0;
        for (int i = 0; i < 3; i++) begin slow_tick = 1; cyc(); slow_tick = 0; cyc(); end
        ext_rst_req = 1; cyc(); ext_rst_req = 0; cyc();
        sleep_wr = 1; cyc(); sleep_wr = 0;
        slow_tick = 1; cyc(); slow_tick = 0;
        check("R11 count restarted", wake_rst, 0);
        ext_rst_req = 1; cyc(); ext_rst_req = 0; cyc();
    endtask

    task automatic t_scr_inhibit();
        scr_sel = 0; scr_inhibit = 1;
        sleep_wr = 1; cyc(); sleep_wr = 0;
        for (int i = 0; i < 40; i++) begin
            slow_tick = 1; cyc(); slow_tick = 0;
            if (wake_rst !== 1'b0) check("R11 inhibited wake", wake_rst, 0);
        end
        check("R11 stays deep", mode, 2);
        ext_rst_req = 1; cyc(); ext_rst_req = 0; cyc();
        check("R11 exit by pin", mode, 0);
        scr_inhibit = 0;
    endtask

    task automatic t_collide();
        scr_sel = 0;
        sleep_wr = 1; cyc(); sleep_wr = 0;
        for (int i = 0; i < 3; i++) begin slow_tick = 1; cyc(); slow_tick = 0; end
        slow_tick = 1; ext_rst_req = 1; cyc(); slow_tick = 0; ext_rst_req = 0;
        check("R10 collide pulse", wake_rst, 1);
        check("R9 collide reset", mode, 3);
        cyc();
        check("R9 collide single", mode, 0);
        check("R10 collide pulse ends", wake_rst, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_halt_irq();
        t_sleep_blocked();
        t_deep_pin_wake();
        t_pin_option();
        t_scr(3'd0);
        t_scr(3'd2);
        t_scr_restart();
        t_scr_inhibit();
        t_collide();
        t_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule